// File: doc/BRIEF.md
# Synchronizer Output Causality Monitor

This block watches the input and the output of a clock-domain synchronizer whose latency is not fixed but falls anywhere from `LAT_MIN` to `LAT_MAX` cycles. It samples both signals on every rising clock edge and keeps a record of recent rising and falling edges of the synchronizer input. Whenever the output changes, the monitor looks back over that record. It accepts the change only when the input made a transition of the same direction within the allowed latency window.

An output edge with no matching cause raises a registered one-cycle error pulse and sets a sticky error flag. The sticky flag holds until the next reset. The monitor is synthesizable, so it can sit next to the synchronizer in silicon or in an emulation build as well as in simulation.

The edge of a signal is assigned to the first clock edge at which its new value is sampled. The distance between cause and effect is the number of clock edges between those two sampling points.

Top module: `sync_causality_mon`

## Requirements
- R1: A rise of `sync_o` is accepted without error when `sync_i` rose at a distance d edges earlier, for every d with LAT_MIN <= d <= LAT_MAX.
- R2: A fall of `sync_o` is accepted without error when `sync_i` fell at a distance d edges earlier, for every d with LAT_MIN <= d <= LAT_MAX.
- R3: An output edge whose only same-direction input edge lies fewer than LAT_MIN edges back is flagged as an error.
- R4: An output edge whose only same-direction input edge lies more than LAT_MAX edges back is flagged as an error.
- R5: Polarity must match. An output rise caused only by an input fall, or an output fall caused only by an input rise, is flagged as an error.
- R6: An output edge with no input edge in the window is flagged as an error.
- R7: The error pulse `err_pulse_o` is high for the single cycle that follows the clock edge at which the offending output edge was sampled. It is low in the next cycle unless another offending edge was sampled.
- R8: `err_sticky_o` goes high together with the first error pulse and stays high until `rst_ni` is asserted.
- R9: While `rst_ni` is low, both outputs are 0 and no check is made. After release, output edges sampled during the first LAT_MAX+1 clock edges are not checked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock of the synchronizer's destination domain |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Synchronizer input, already in the clock domain being sampled |
| sync_o | input | 1 | Synchronizer output under observation |
| err_pulse_o | output | 1 | One-cycle pulse per unexplained output edge |
| err_sticky_o | output | 1 | Error flag held until reset |

## Verification
The bench builds the monitor with LAT_MIN=2 and LAT_MAX=4, so a full sweep stays short. It steps the distance from 0 to LAT_MAX+2 for both polarities, which covers both window bounds and one cycle beyond each. It also drives output edges with no cause, edges of the wrong direction, and edges inside the disarmed interval after reset. A model synchronizer with a random latency inside the window then runs many edges and must never raise an error.

// File: rtl/sync_mon_pkg.sv
package sync_mon_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/sm_edge_det.sv
module sm_edge_det
  import sync_mon_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sig_i,
  output edge_t edge_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign edge_o.rise = sig_i & ~sig_q;
  assign edge_o.fall = ~sig_i & sig_q;
endmodule

// File: rtl/sm_edge_hist.sv
// Shift history of one edge kind; hist_q[k] holds the edge seen k+1 clocks ago.
module sm_edge_hist #(
  parameter int unsigned LAT_MIN = 2,
  parameter int unsigned LAT_MAX = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  output logic hit_o
);
  localparam int unsigned DEPTH = LAT_MAX;

  logic [DEPTH-1:0] hist_q;
  logic [DEPTH-1:0] win_bits;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '0;
        else         hist_q <= edge_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '0;
        else         hist_q <= {hist_q[DEPTH-2:0], edge_i};
      end
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_win
      if (k + 1 >= LAT_MIN) begin : g_in
        assign win_bits[k] = hist_q[k];
      end else begin : g_out
        assign win_bits[k] = 1'b0;
      end
    end
  endgenerate

  assign hit_o = |win_bits;
endmodule

// File: rtl/sm_arm_cnt.sv
module sm_arm_cnt #(
  parameter int unsigned ARM_CYC = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic armed_o
);
  localparam int unsigned CNT_W = $clog2(ARM_CYC + 1);
  localparam logic [CNT_W-1:0] ARM_VAL = CNT_W'(ARM_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (cnt_q != ARM_VAL) cnt_q <= cnt_q + 1'b1;
  end

  assign armed_o = (cnt_q == ARM_VAL);
endmodule

// File: rtl/sync_causality_mon.sv
module sync_causality_mon
  import sync_mon_pkg::*;
#(
  parameter int unsigned LAT_MIN = 2,
  parameter int unsigned LAT_MAX = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic sync_o,
  output logic err_pulse_o,
  output logic err_sticky_o
);
  localparam int unsigned ARM_CYC = LAT_MAX + 1;

  edge_t in_edge, out_edge;
  logic  rise_hit, fall_hit, armed, viol;

  sm_edge_det u_in_det  (.clk_i(clk_i), .rst_ni(rst_ni), .sig_i(sync_i), .edge_o(in_edge));
  sm_edge_det u_out_det (.clk_i(clk_i), .rst_ni(rst_ni), .sig_i(sync_o), .edge_o(out_edge));

  sm_edge_hist #(.LAT_MIN(LAT_MIN), .LAT_MAX(LAT_MAX)) u_rise_hist (
    .clk_i(clk_i), .rst_ni(rst_ni), .edge_i(in_edge.rise), .hit_o(rise_hit));
  sm_edge_hist #(.LAT_MIN(LAT_MIN), .LAT_MAX(LAT_MAX)) u_fall_hist (
    .clk_i(clk_i), .rst_ni(rst_ni), .edge_i(in_edge.fall), .hit_o(fall_hit));

  sm_arm_cnt #(.ARM_CYC(ARM_CYC)) u_arm (.clk_i(clk_i), .rst_ni(rst_ni), .armed_o(armed));

  assign viol = armed & ((out_edge.rise & ~rise_hit) | (out_edge.fall & ~fall_hit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_pulse_o  <= 1'b0;
      err_sticky_o <= 1'b0;
    end else begin
      err_pulse_o  <= viol;
      if (viol) err_sticky_o <= 1'b1;
    end
  end

  AST_PULSE_SETS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_o |-> err_sticky_o); // R8
  AST_STICKY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_sticky_o |=> err_sticky_o); // R8
  AST_NO_ERR_UNARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |=> !err_pulse_o); // R9
  AST_PULSE_NEEDS_OUT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_o |-> ($past(sync_o) != $past(sync_o, 2))); // R7
endmodule

// File: tb/sync_causality_mon_tb.sv
`timescale 1ns/1ps
module sync_causality_mon_tb;
  localparam int unsigned LMIN = 2;
  localparam int unsigned LMAX = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic a = 1'b0, b = 1'b0;
  logic err_p, err_s;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  sync_causality_mon #(.LAT_MIN(LMIN), .LAT_MAX(LMAX)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sync_i(a), .sync_o(b),
    .err_pulse_o(err_p), .err_sticky_o(err_s));

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic la, input logic lb);
    @(negedge clk);
    rst_ni = 1'b0; a = la; b = lb;
    @(negedge clk);
    b = ~lb;  // toggles under reset must not be checked
    @(negedge clk);
    b = lb;
    chk(err_p, 1'b0, "R9 pulse in reset");
    chk(err_s, 1'b0, "R9 sticky in reset");
    rst_ni = 1'b1;
    repeat (LMAX + 3) @(negedge clk);
    chk(err_s, 1'b0, "R9 sticky after arm");
  endtask

  // input edge, then output edge d clocks later, directions chosen separately
  task automatic edge_pair(input int d, input logic a_rise, input logic b_rise,
                           input logic exp, input string tag);
    do_reset(~a_rise, ~b_rise);
    a = a_rise;
    repeat (d) @(negedge clk);
    b = b_rise;
    @(negedge clk);
    chk(err_p, exp, {tag, " pulse"});
    @(negedge clk);
    chk(err_p, 1'b0, "R7 pulse width");
    chk(err_s, exp, {tag, " sticky"});
    repeat (LMAX + 2) @(negedge clk);
    chk(err_s, exp, "R8 sticky hold");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(err_p, 1'b0, "R9 reset pulse");
    chk(err_s, 1'b0, "R9 reset sticky");

    // distance sweep, both polarities
    for (int pol = 0; pol < 2; pol++) begin
      for (int d = 0; d <= LMAX + 2; d++) begin
        logic exp;
        exp = (d < LMIN) || (d > LMAX);
        if (pol == 0)
          edge_pair(d, 1'b1, 1'b1, exp, d < LMIN ? "R3 rise" : (d > LMAX ? "R4 rise" : "R1"));
        else
          edge_pair(d, 1'b0, 1'b0, exp, d < LMIN ? "R3 fall" : (d > LMAX ? "R4 fall" : "R2"));
      end
    end

    // polarity mismatch anywhere in the window
    for (int d = LMIN; d <= LMAX; d++) begin
      edge_pair(d, 1'b1, 1'b0, 1'b1, "R5 in-rise out-fall");
      edge_pair(d, 1'b0, 1'b1, 1'b1, "R5 in-fall out-rise");
    end

    // output edge with no cause
    do_reset(1'b0, 1'b0);
    b = 1'b1;
    @(negedge clk);
    chk(err_p, 1'b1, "R6 no cause");
    @(negedge clk);
    chk(err_s, 1'b1, "R8 sticky set");
    do_reset(1'b0, 1'b1);
    chk(err_s, 1'b0, "R8 cleared by reset");

    // disarmed interval right after release
    @(negedge clk);
    rst_ni = 1'b0; a = 1'b0; b = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    for (int k = 0; k < LMAX + 1; k++) begin
      b = ~b;
      @(negedge clk);
      chk(err_p, 1'b0, "R9 disarmed");
    end
    @(negedge clk);
    chk(err_s, 1'b0, "R9 disarmed sticky");

    // model synchronizer with random latency in the window
    do_reset(1'b0, 1'b0);
    for (int it = 0; it < 60; it++) begin
      int d;
      d = $urandom_range(LMAX, LMIN);
      a = ~a;
      repeat (d) begin
        @(negedge clk);
        chk(err_p, 1'b0, a ? "R1 model" : "R2 model");
      end
      b = a;
      repeat (LMAX + 1 + $urandom_range(2, 0)) begin
        @(negedge clk);
        chk(err_p, 1'b0, b ? "R1 model" : "R2 model");
      end
    end
    chk(err_s, 1'b0, "R1 R2 model sticky");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule